// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This block is the arithmetic core that an 8-bit processor uses for its add-with-carry and subtract-with-borrow operations. It takes the accumulator value, a second operand, the incoming carry, a decimal-mode select and an operation select. It returns the 8-bit result and four condition flags: negative, overflow, zero and carry. Instruction decode, addressing and the flag register itself are outside the block. The surrounding datapath feeds the flags back as it needs them.

In binary mode the unit is an ordinary two's-complement adder/subtractor. In decimal mode each operand byte holds two BCD digits and the result is digit-corrected. The flags in decimal mode follow fixed rules that differ from the plain BCD reading. On an add, zero comes from the uncorrected binary sum. Negative and overflow come from the high digit before its final correction. On a subtract, every flag comes from the binary difference and only the result byte is corrected.

The logic is combinational. A parameter `REG_OUT` selects an optional output register with synchronous active-low reset; it defaults to registered, with one cycle of latency.

Top module: `bcd_alu`

## Requirements
- R1: Binary add (`sub_i`=0, `dec_i`=0) gives `res_o` = low byte of acc+opnd+cin, and `c_o`=1 exactly when that sum is above 255.
- R2: In binary add, `v_o`=1 when acc bit 7 equals opnd bit 7 and result bit 7 differs from acc bit 7; `n_o` is result bit 7; `z_o`=1 when the result byte is 0.
- R3: Decimal add forms the low digit as low nibbles plus cin, adding 6 when that exceeds 9. It adds one into the high digit when the corrected low digit exceeds 15. For valid BCD inputs, both result nibbles are at most 9.
- R4: In decimal add, `z_o`=1 exactly when the low byte of the binary sum acc+opnd+cin is 0.
- R5: In decimal add, the raw high digit is the high nibbles plus the low-digit carry. `n_o` is bit 3 of that raw digit. `v_o`=1 when acc and opnd bit 7 agree and raw-digit bit 3 differs from acc bit 7.
- R6: In decimal add, a raw high digit above 9 gets 6 added. `c_o`=1 when the corrected high digit exceeds 15. `res_o` is {corrected high nibble, corrected low nibble}.
- R7: Subtract (`sub_i`=1) in binary mode gives `res_o` = low byte of acc−opnd−(1−cin). `c_o`=1 when no borrow occurs. `v_o`=1 when acc and opnd signs differ and result sign differs from acc. `n_o` is result bit 7 and `z_o`=1 for a zero result.
- R8: In decimal subtract, `n_o`, `v_o`, `z_o` and `c_o` equal the binary-subtract flags for the same inputs.
- R9: In decimal subtract, the low digit is low nibbles difference minus (1−cin). If bit 4 of that difference is set, it has 6 subtracted and the high difference is decremented. If the high difference then has bit 4 set, it has 6 subtracted. `res_o` takes the low nibble of each.
- R10: `sub_i`=0 selects add and 1 selects subtract; `dec_i`=1 selects decimal mode and 0 binary.
- R11: With `REG_OUT`=1 the outputs show the function of the inputs sampled at the previous rising clock edge. While `rst_n` is low at an edge, all outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| cin_i | input | 1 | Incoming carry (1 = no borrow on subtract) |
| dec_i | input | 1 | 1 = packed-decimal mode |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| res_o | output | 8 | Result byte |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry / no-borrow flag |

## Verification
The bench sweeps every accumulator value against a strided set of operand values, in all eight combinations of carry, mode and operation. Binary and decimal runs separate the plain adder from the digit correction. Operands that are not valid BCD expose the decimal-flag rules, where zero, negative and overflow diverge from the corrected result. Directed vectors add the digit-wrap cases: 99+1, 0−1 with borrow, and halves at 9 and 15.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  typedef struct packed {
    logic [7:0] res;
    logic       n;
    logic       v;
    logic       z;
    logic       c;
  } alu_out_t;

  // Plain two's-complement add or subtract with flags
  function automatic alu_out_t f_bin(input logic [7:0] a, input logic [7:0] b,
                                     input logic ci, input logic sub);
    alu_out_t   o;
    logic [8:0] s;
    if (sub) begin
      s   = {1'b0, a} - {1'b0, b} - {8'b0, ~ci};
      o.c = ~s[8];
      o.v = (a[7] ^ s[7]) & (a[7] ^ b[7]);
    end else begin
      s   = {1'b0, a} + {1'b0, b} + {8'b0, ci};
      o.c = s[8];
      o.v = ~(a[7] ^ b[7]) & (a[7] ^ s[7]);
    end
    o.res = s[7:0];
    o.n   = s[7];
    o.z   = (s[7:0] == 8'h00);
    return o;
  endfunction

  // Raw high digit of a decimal add (before its own correction)
  function automatic logic [5:0] f_dadd_hi_raw(input logic [7:0] a, input logic [7:0] b,
                                               input logic ci);
    logic [5:0] lo;
    lo = {2'b0, a[3:0]} + {2'b0, b[3:0]} + {5'b0, ci};
    if (lo > 6'd9) lo = lo + 6'd6;
    return {2'b0, a[7:4]} + {2'b0, b[7:4]} + {5'b0, (lo > 6'd15)};
  endfunction

  function automatic logic [3:0] f_dadd_lo(input logic [7:0] a, input logic [7:0] b,
                                           input logic ci);
    logic [5:0] lo;
    lo = {2'b0, a[3:0]} + {2'b0, b[3:0]} + {5'b0, ci};
    if (lo > 6'd9) lo = lo + 6'd6;
    return lo[3:0];
  endfunction

  // Corrected result byte of a decimal subtract
  function automatic logic [7:0] f_dsub(input logic [7:0] a, input logic [7:0] b,
                                        input logic ci);
    logic [4:0] lo, hi;
    lo = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, ~ci};
    hi = {1'b0, a[7:4]} - {1'b0, b[7:4]};
    if (lo[4]) begin
      lo = lo - 5'd6;
      hi = hi - 5'd1;
    end
    if (hi[4]) hi = hi - 5'd6;
    return {hi[3:0], lo[3:0]};
  endfunction

endpackage

// File: rtl/bcd_alu_bin.sv
module bcd_alu_bin
  import bcd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  input  logic         sub_i,
  output alu_out_t     bin_o
);
  assign bin_o = f_bin(a_i, b_i, ci_i, sub_i);
endmodule

// File: rtl/bcd_alu_dec.sv
module bcd_alu_dec
  import bcd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] add_res_o,
  output logic         add_n_o,
  output logic         add_v_o,
  output logic         add_c_o,
  output logic [5:0]   hi_raw_o,
  output logic [W-1:0] sub_res_o
);
  logic [5:0] hi_adj;

  assign hi_raw_o = f_dadd_hi_raw(a_i, b_i, ci_i);
  assign add_n_o  = hi_raw_o[3];
  assign add_v_o  = ~(a_i[7] ^ b_i[7]) & (hi_raw_o[3] ^ a_i[7]);
  assign hi_adj   = (hi_raw_o > 6'd9) ? hi_raw_o + 6'd6 : hi_raw_o;
  assign add_c_o  = (hi_adj > 6'd15);
  assign add_res_o = {hi_adj[3:0], f_dadd_lo(a_i, b_i, ci_i)};
  assign sub_res_o = f_dsub(a_i, b_i, ci_i);
endmodule

// File: rtl/bcd_alu_oreg.sv
module bcd_alu_oreg
  import bcd_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  alu_out_t d_i,
  output alu_out_t q_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
      end

      AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q_o == $past(d_i))); // R11
    end else begin : g_comb
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       cin_i,
  input  logic       dec_i,
  input  logic       sub_i,
  output logic [7:0] res_o,
  output logic       n_o,
  output logic       v_o,
  output logic       z_o,
  output logic       c_o
);
  localparam int W = 8;

  alu_out_t       bin_w;
  alu_out_t       comb_w;
  alu_out_t       q_w;
  logic [W-1:0]   dadd_res_w;
  logic           dadd_n_w;
  logic           dadd_v_w;
  logic           dadd_c_w;
  logic [5:0]     dadd_hi_raw_w;
  logic [W-1:0]   dsub_res_w;

  bcd_alu_bin #(.W(W)) u_bin (
    .a_i(acc_i), .b_i(opnd_i), .ci_i(cin_i), .sub_i(sub_i), .bin_o(bin_w)
  );

  bcd_alu_dec #(.W(W)) u_dec (
    .a_i(acc_i), .b_i(opnd_i), .ci_i(cin_i),
    .add_res_o(dadd_res_w), .add_n_o(dadd_n_w), .add_v_o(dadd_v_w),
    .add_c_o(dadd_c_w), .hi_raw_o(dadd_hi_raw_w), .sub_res_o(dsub_res_w)
  );

  // Mode select: decimal subtract keeps binary flags, decimal add keeps binary Z
  always_comb begin
    comb_w = bin_w;
    if (dec_i) begin
      if (sub_i) begin
        comb_w.res = dsub_res_w;
      end else begin
        comb_w.res = dadd_res_w;
        comb_w.n   = dadd_n_w;
        comb_w.v   = dadd_v_w;
        comb_w.c   = dadd_c_w;
      end
    end
  end

  AST_BIN_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_i && !sub_i) |-> (comb_w.c == (({1'b0, acc_i} + {1'b0, opnd_i} + {8'b0, cin_i}) > 9'd255))); // R1
  AST_DEC_ADD_Z_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !sub_i) |-> (comb_w.z == ((acc_i + opnd_i + {7'b0, cin_i}) == 8'h00))); // R4
  AST_DEC_ADD_N_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !sub_i) |-> (comb_w.n == dadd_hi_raw_w[3])); // R5
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !sub_i && acc_i[3:0] <= 4'd9 && acc_i[7:4] <= 4'd9 &&
     opnd_i[3:0] <= 4'd9 && opnd_i[7:4] <= 4'd9)
    |-> (comb_w.res[3:0] <= 4'd9 && comb_w.res[7:4] <= 4'd9)); // R3
  AST_DEC_SUB_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && sub_i) |-> (comb_w.c == ({1'b0, acc_i} >= ({1'b0, opnd_i} + {8'b0, ~cin_i})))); // R8

  bcd_alu_oreg #(.REG_OUT(REG_OUT)) u_oreg (
    .clk(clk), .rst_n(rst_n), .d_i(comb_w), .q_o(q_w)
  );

  assign res_o = q_w.res;
  assign n_o   = q_w.n;
  assign v_o   = q_w.v;
  assign z_o   = q_w.z;
  assign c_o   = q_w.c;
endmodule

// File: tb/bcd_alu_bench.sv
module bcd_alu_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] opnd_i = 8'h00;
  logic       cin_i = 1'b0;
  logic       dec_i = 1'b0;
  logic       sub_i = 1'b0;
  logic [7:0] res_o;
  logic       n_o, v_o, z_o, c_o;

  logic       drv_vld = 1'b0;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         finished = 1'b0;
  logic [30:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_alu u_bcd_alu (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opnd_i(opnd_i), .cin_i(cin_i),
    .dec_i(dec_i), .sub_i(sub_i), .res_o(res_o), .n_o(n_o), .v_o(v_o),
    .z_o(z_o), .c_o(c_o)
  );

  // Reference model, integer arithmetic; returns {res, n, v, z, c}
  function automatic logic [11:0] model(int a, int b, int c, bit d, bit s);
    int r, t, lo, hi;
    bit fn, fv, fz, fc;
    if (!s) begin
      t = a + b + c;
      if (!d) begin                        // R1 R2
        r  = t & 255;
        fc = (t > 255);
        fv = (((a ^ b) & 128) == 0) && (((a ^ t) & 128) != 0);
        fn = (r & 128) != 0;
        fz = (r == 0);
      end else begin                       // R3 R4 R5 R6
        lo = (a & 15) + (b & 15) + c;
        if (lo > 9) lo = lo + 6;
        hi = (a >> 4) + (b >> 4) + ((lo > 15) ? 1 : 0);
        fz = ((t & 255) == 0);
        fn = (hi & 8) != 0;
        fv = ((((hi << 4) ^ a) & 128) != 0) && (((a ^ b) & 128) == 0);
        if (hi > 9) hi = hi + 6;
        fc = (hi > 15);
        r  = ((hi & 15) << 4) | (lo & 15);
      end
    end else begin                         // R7 R8 R9
      t  = a - b - (c != 0 ? 0 : 1);
      fc = (t >= 0);
      fv = (((a ^ t) & 128) != 0) && (((a ^ b) & 128) != 0);
      fn = (t & 128) != 0;
      fz = ((t & 255) == 0);
      r  = t & 255;
      if (d) begin
        lo = (a & 15) - (b & 15) - (c != 0 ? 0 : 1);
        hi = (a >> 4) - (b >> 4);
        if ((lo & 16) != 0) begin
          lo = lo - 6;
          hi = hi - 1;
        end
        if ((hi & 16) != 0) hi = hi - 6;
        r = ((hi & 15) << 4) | (lo & 15);
      end
    end
    return {r[7:0], fn, fv, fz, fc};
  endfunction

  // Driver: R10 encoding, sub=1 subtract, dec=1 decimal
  task automatic apply(int a, int b, int c, bit d, bit s);
    logic [11:0] e;
    e = model(a, b, c, d, s);
    @(negedge clk);
    acc_i   = a[7:0];
    opnd_i  = b[7:0];
    cin_i   = c[0];
    dec_i   = d;
    sub_i   = s;
    drv_vld = 1'b1;
    exp_q.push_back({a[7:0], b[7:0], c[0], d, s, e});
  endtask

  function automatic string tag_for(bit d, bit s, int fld);
    if (fld == 0) return !s ? (!d ? "R1" : "R6") : (!d ? "R7" : "R9");
    if (fld == 4) return !s ? (!d ? "R1" : "R6") : (!d ? "R7" : "R8");
    if (fld == 3) return !s ? (!d ? "R2" : "R4") : (!d ? "R7" : "R8");
    return !s ? (!d ? "R2" : "R5") : (!d ? "R7" : "R8");
  endfunction

  // Monitor: with one output register, results appear just after the edge that sampled them (R11)
  initial begin
    forever begin
      logic        take;
      logic [30:0] it;
      logic [11:0] act;
      int          fld;
      @(posedge clk);
      take = drv_vld;
      #1;
      if (take && exp_q.size() > 0) begin
        it  = exp_q.pop_front();
        act = {res_o, n_o, v_o, z_o, c_o};
        n_vec++;
        if (act !== it[11:0]) begin
          n_bad++;
          if (act[11:4] !== it[11:4]) fld = 0;
          else if (act[3] !== it[3])  fld = 1;
          else if (act[2] !== it[2])  fld = 2;
          else if (act[1] !== it[1])  fld = 3;
          else                        fld = 4;
          $display("FAIL %s a=%02h b=%02h c=%0d dec=%0d sub=%0d actual res=%02h nvzc=%04b expected res=%02h nvzc=%04b",
                   tag_for(it[13], it[12], fld), it[30:23], it[22:15], it[14], it[13], it[12],
                   act[11:4], act[3:0], it[11:4], it[3:0]);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R11: reset clears all outputs
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if ({res_o, n_o, v_o, z_o, c_o} !== 12'h000) begin
      n_bad++;
      $display("FAIL R11 reset actual=%03h expected=000", {res_o, n_o, v_o, z_o, c_o});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Directed digit-wrap corners
    apply(8'h99, 8'h01, 0, 1'b1, 1'b0);  // R3 R6: 99+1 wraps to 00 with carry
    apply(8'h09, 8'h00, 1, 1'b1, 1'b0);  // R3: low digit 9+carry
    apply(8'h0F, 8'h0F, 1, 1'b1, 1'b0);  // R3: invalid digits past 15
    apply(8'h50, 8'h50, 0, 1'b1, 1'b0);  // R5: raw high digit sets N/V
    apply(8'hFF, 8'h01, 0, 1'b1, 1'b0);  // R4: binary sum zero
    apply(8'h00, 8'h01, 1, 1'b1, 1'b1);  // R9: 0-1 borrows both digits
    apply(8'h10, 8'h01, 1, 1'b1, 1'b1);  // R9: low borrow only
    apply(8'h00, 8'h00, 0, 1'b1, 1'b1);  // R8 R9: borrow in
    apply(8'h80, 8'h01, 1, 1'b0, 1'b1);  // R7: signed overflow
    apply(8'h7F, 8'h01, 0, 1'b0, 1'b0);  // R2: signed overflow
    apply(8'hFF, 8'h00, 1, 1'b0, 1'b0);  // R1: carry out, zero result

    // Sweep: all accumulators, strided operands, every carry/mode/op (R10)
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 5)
              apply(a, b, c, d[0], s[0]);

    @(negedge clk);
    drv_vld = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 pending actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule